// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block combines four reset requests into one internal core reset and controls how that reset is released. The four requests are the power-on reset (`rst_ni`), an external reset pin that is active low, a low-voltage detector request and a watchdog request. The pin is synchronized inside the block. The power-on and pin requests are the slow requests. After either of them the block turns the oscillator off. It then waits for the supply-ready flag, turns the oscillator on, and counts a stabilisation window before it releases the core. When the core runs from an external clock, a second window follows. Its length is scaled by an 8-bit wakeup prescaler, and the prescaler value is captured at the moment the first window ends.

The watchdog and low-voltage requests are the fast requests. They leave the oscillator running, and the core is released on the first clock edge at which no request is present. A new request that arrives during a count stops that count, and the whole sequence starts again. Once a slow request is pending, the restart takes the slow path. When the reset is released, the block gives a single-cycle start pulse, and the core begins fetching from address 0.

A sticky cause register records every source that has requested a reset. Software clears it with a strobe, and a power-on reset also clears it.

Top module: `reset_sequencer`

## Requirements
- R1: `core_rst_o` is high while any request is active, during the asynchronous power-on reset, and for the whole of any release sequence. It is low only after a release has completed.
- R2: `ext_rst_ni` is active low and passes through two synchronizer flops. If the pin falls before clock edge 1, `core_rst_o` and the oscillator-off action appear only after edge 3.
- R3: After a power-on or pin reset, `osc_en_o` is low. It stays low, and no release happens, for as long as `supply_ok_i` is low.
- R4: When `clk_ext_i`=0, `core_start_o` rises exactly STAB_CYC (4096) cycles after `osc_en_o` rises.
- R5: When `clk_ext_i`=1, `core_start_o` rises exactly STAB_CYC×(W+2) cycles after `osc_en_o` rises. W is the value of `wakeup_i` captured when the first window ends. Later changes to `wakeup_i` have no effect.
- R6: A watchdog or low-voltage request does not change `osc_en_o`. `core_start_o` is high in the cycle after the first clock edge at which no request is sampled.
- R7: A request that arrives during a count restarts the sequence from the beginning with cleared counters. While a slow request is pending, the restart goes through the supply check and the full window. When the supply is already ready, release comes STAB_CYC+2 cycles after the first request-free edge.
- R8: `core_start_o` is a single-cycle pulse. It is high exactly in the first cycle in which `core_rst_o` is low.
- R9: `cause_o` bit 0 is power-on, bit 1 is pin, bit 2 is low-voltage and bit 3 is watchdog. The bits are sticky. A power-on reset loads 4'b0001. `cause_clr_i` clears all bits in the next cycle, and a request arriving in the same cycle as the clear takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous to the clock |
| wdg_req_i | input | 1 | Watchdog reset request |
| lvd_req_i | input | 1 | Low-voltage reset request |
| supply_ok_i | input | 1 | Internal supply has reached its operating level |
| clk_ext_i | input | 1 | 1 = external oscillator, 0 = internal clock |
| wakeup_i | input | WK_W | Wakeup prescaler for the second window |
| cause_clr_i | input | 1 | Clear strobe for the cause flags |
| osc_en_o | output | 1 | Oscillator enable |
| core_rst_o | output | 1 | Internal core reset, active high |
| core_start_o | output | 1 | One-cycle pulse when the core is released |
| cause_o | output | 4 | Sticky reset-cause flags |

## Verification
Most internal faults in this block show up as a release time that is wrong. A counter that is off by one, or a window that is not scaled, moves `core_start_o` by one cycle or by a whole window. That difference is visible in the first release that follows. A path-selection latch that is wrong shows up within a few cycles, either as an immediate release where a full count was expected or as an oscillator enable that drops after a fast request. A synchronizer depth that is wrong moves the reset assertion by a cycle right after the pin falls. A cause register fault is visible on `cause_o` one cycle after the request or the clear.

// File: rtl/reset_seq_pkg.sv
package reset_seq_pkg;
  typedef enum logic [2:0] {
    ST_HOLD,
    ST_SUPPLY,
    ST_STAB,
    ST_WAKE,
    ST_RUN
  } seq_state_e;

  localparam int CAUSE_N   = 4;
  localparam int CAUSE_POR = 0;
  localparam int CAUSE_PIN = 1;
  localparam int CAUSE_LVD = 2;
  localparam int CAUSE_WDG = 3;
endpackage

// File: rtl/reset_pin_sync.sv
module reset_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic pin_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], pin_ni};
  end

  assign pin_no = sync_q[STAGES-1];
endmodule

// File: rtl/reset_delay_cnt.sv
module reset_delay_cnt #(
  parameter int BASE   = 4096,
  parameter int MULT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [MULT_W-1:0] mult_lim_i,
  output logic              base_done_o,
  output logic              all_done_o
);
  localparam int BW = (BASE > 2) ? $clog2(BASE) : 1;
  localparam logic [BW-1:0] BASE_LAST = BW'(BASE - 1);

  logic [BW-1:0]     base_q;
  logic [MULT_W-1:0] mult_q;

  assign base_done_o = (base_q == BASE_LAST);
  assign all_done_o  = base_done_o && (mult_q == mult_lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      mult_q <= '0;
    end else if (clr_i) begin
      base_q <= '0;
      mult_q <= '0;
    end else if (en_i) begin
      if (base_done_o) begin
        base_q <= '0;
        mult_q <= mult_q + MULT_W'(1);
      end else begin
        base_q <= base_q + BW'(1);
      end
    end
  end
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
  import reset_seq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CAUSE_N-1:0] set_i,
  input  logic               clr_i,
  output logic [CAUSE_N-1:0] cause_o
);
  logic [CAUSE_N-1:0] cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= CAUSE_N'(1) << CAUSE_POR;
    else         cause_q <= (clr_i ? '0 : cause_q) | set_i;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import reset_seq_pkg::*;
#(
  parameter int STAB_CYC = 4096,
  parameter int WK_W     = 8,
  parameter int SYNC_STG = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_rst_ni,
  input  logic               wdg_req_i,
  input  logic               lvd_req_i,
  input  logic               supply_ok_i,
  input  logic               clk_ext_i,
  input  logic [WK_W-1:0]    wakeup_i,
  input  logic               cause_clr_i,
  output logic               osc_en_o,
  output logic               core_rst_o,
  output logic               core_start_o,
  output logic [CAUSE_N-1:0] cause_o
);
  seq_state_e state_q, state_d;
  logic pin_n, slow_req, fast_req, any_req;
  logic slow_pend_q, osc_q, start_q;
  logic [WK_W-1:0] wk_q;
  logic cnt_clr, cnt_en, base_done, all_done;
  logic [CAUSE_N-1:0] cause_set;

  reset_pin_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i, .rst_ni, .pin_ni(ext_rst_ni), .pin_no(pin_n)
  );

  assign slow_req = !pin_n;
  assign fast_req = wdg_req_i | lvd_req_i;
  assign any_req  = slow_req | fast_req;

  always_comb begin
    state_d = state_q;
    if (any_req) state_d = ST_HOLD;
    else begin
      unique case (state_q)
        ST_HOLD:   state_d = slow_pend_q ? ST_SUPPLY : ST_RUN;
        ST_SUPPLY: if (supply_ok_i) state_d = ST_STAB;
        ST_STAB:   if (base_done) state_d = clk_ext_i ? ST_WAKE : ST_RUN;
        ST_WAKE:   if (all_done) state_d = ST_RUN;
        ST_RUN:    state_d = ST_RUN;
        default:   state_d = ST_HOLD;
      endcase
    end
  end

  // counters restart on every state change, so a new request always begins afresh
  assign cnt_clr = (state_d != state_q);
  assign cnt_en  = (state_q == ST_STAB) || (state_q == ST_WAKE);

  reset_delay_cnt #(.BASE(STAB_CYC), .MULT_W(WK_W)) u_cnt (
    .clk_i, .rst_ni, .clr_i(cnt_clr), .en_i(cnt_en),
    .mult_lim_i(wk_q), .base_done_o(base_done), .all_done_o(all_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_HOLD;
      slow_pend_q <= 1'b1;
      osc_q       <= 1'b0;
      start_q     <= 1'b0;
      wk_q        <= '0;
    end else begin
      state_q <= state_d;
      start_q <= (state_d == ST_RUN) && (state_q != ST_RUN);
      if (slow_req)                slow_pend_q <= 1'b1;
      else if (state_d == ST_RUN)  slow_pend_q <= 1'b0;
      if (slow_req)                                           osc_q <= 1'b0;
      else if ((state_d == ST_STAB) && (state_q != ST_STAB))  osc_q <= 1'b1;
      if ((state_q == ST_STAB) && (state_d == ST_WAKE)) wk_q <= wakeup_i;
    end
  end

  always_comb begin
    cause_set            = '0;
    cause_set[CAUSE_PIN] = slow_req;
    cause_set[CAUSE_LVD] = lvd_req_i;
    cause_set[CAUSE_WDG] = wdg_req_i;
  end

  reset_cause_reg u_cause (
    .clk_i, .rst_ni, .set_i(cause_set), .clr_i(cause_clr_i), .cause_o
  );

  assign osc_en_o     = osc_q;
  assign core_rst_o   = (state_q != ST_RUN);
  assign core_start_o = start_q;
endmodule

// File: rtl/reset_sequencer_chk.sv
module reset_sequencer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wdg_req_i,
  input logic       lvd_req_i,
  input logic       osc_en_o,
  input logic       core_rst_o,
  input logic       core_start_o,
  input logic [3:0] cause_o
);
  a_r8_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_start_o |=> !core_start_o);

  a_r8_start_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_start_o |-> (!core_rst_o && $past(core_rst_o)));

  a_r1_fast_req_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdg_req_i || lvd_req_i) |=> core_rst_o);

  a_r3_osc_before_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_start_o |-> osc_en_o);

  a_r9_wdg_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdg_req_i |=> cause_o[3]);

  a_r9_lvd_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvd_req_i |=> cause_o[2]);
endmodule

bind reset_sequencer reset_sequencer_chk u_chk (.*);

// File: tb/sim_reset_sequencer.sv
module sim_reset_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int STAB = 4096;

  logic clk = 1'b0, rst_ni = 1'b0, ext_rst_ni = 1'b1, wdg_req_i = 1'b0, lvd_req_i = 1'b0;
  logic supply_ok_i = 1'b0, clk_ext_i = 1'b0, cause_clr_i = 1'b0;
  logic [7:0] wakeup_i = '0;
  logic osc_en_o, core_rst_o, core_start_o;
  logic [3:0] cause_o;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_sequencer u0 (
    .clk_i(clk), .rst_ni, .ext_rst_ni, .wdg_req_i, .lvd_req_i, .supply_ok_i,
    .clk_ext_i, .wakeup_i, .cause_clr_i, .osc_en_o, .core_rst_o, .core_start_o, .cause_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_osc();
    int k = 0;
    while (!osc_en_o && k < 100) begin @(negedge clk); k++; end
  endtask

  task automatic meas_start(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!core_start_o && n < 60000);
  endtask

  task automatic t_por();
    int n;
    repeat (3) @(negedge clk);
    chk(core_rst_o == 1'b1, "R1 por reset", int'(core_rst_o), 1);
    chk(cause_o == 4'b0001, "R9 por cause", int'(cause_o), 1);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk);
    chk(osc_en_o == 1'b0 && core_rst_o == 1'b1, "R3 supply gate", int'({osc_en_o, core_rst_o}), 1);
    supply_ok_i = 1'b1;
    wait_osc();
    meas_start(n);
    chk(n == STAB, "R4 internal clock window", n, STAB);
    chk(core_rst_o == 1'b0, "R8 release with start", int'(core_rst_o), 0);
    @(negedge clk);
    chk(core_start_o == 1'b0, "R8 start pulse width", int'(core_start_o), 0);
  endtask

  task automatic t_wdg();
    int n;
    wdg_req_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(core_rst_o == 1'b1 && osc_en_o == 1'b1, "R6 wdg keeps osc", int'({core_rst_o, osc_en_o}), 3);
    wdg_req_i = 1'b0;
    meas_start(n);
    chk(n == 1, "R6 wdg fast restart", n, 1);
    chk(cause_o == 4'b1001, "R9 wdg cause", int'(cause_o), 9);
  endtask

  task automatic t_clear();
    cause_clr_i = 1'b1;
    @(negedge clk);
    cause_clr_i = 1'b0;
    chk(cause_o == 4'b0000, "R9 cause clear", int'(cause_o), 0);
    cause_clr_i = 1'b1;
    lvd_req_i = 1'b1;
    @(negedge clk);
    cause_clr_i = 1'b0;
    chk(cause_o == 4'b0100, "R9 set beats clear", int'(cause_o), 4);
  endtask

  task automatic t_lvd();
    int n;
    @(negedge clk);
    chk(osc_en_o == 1'b1 && core_rst_o == 1'b1, "R6 lvd keeps osc", int'({osc_en_o, core_rst_o}), 3);
    lvd_req_i = 1'b0;
    meas_start(n);
    chk(n == 1, "R6 lvd fast restart", n, 1);
  endtask

  task automatic t_pin_ext();
    int n;
    clk_ext_i = 1'b1;
    wakeup_i = 8'd1;
    ext_rst_ni = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(core_rst_o == 1'b0, "R2 sync delay", int'(core_rst_o), 0);
    @(negedge clk);
    chk(core_rst_o == 1'b1 && osc_en_o == 1'b0, "R2 pin asserts", int'({core_rst_o, osc_en_o}), 2);
    repeat (4) @(negedge clk);
    ext_rst_ni = 1'b1;
    wait_osc();
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 6000) wakeup_i = 8'd9;
    end while (!core_start_o && n < 60000);
    chk(n == STAB * 3, "R5 external window latched W=1", n, STAB * 3);
    chk(cause_o[1] == 1'b1, "R9 pin cause", int'(cause_o), 6);
    wakeup_i = 8'd0;
    ext_rst_ni = 1'b0;
    repeat (4) @(negedge clk);
    ext_rst_ni = 1'b1;
    wait_osc();
    meas_start(n);
    chk(n == STAB * 2, "R5 external window W=0", n, STAB * 2);
  endtask

  task automatic t_restart();
    int n;
    clk_ext_i = 1'b0;
    ext_rst_ni = 1'b0;
    repeat (4) @(negedge clk);
    ext_rst_ni = 1'b1;
    wait_osc();
    repeat (1000) @(negedge clk);
    wdg_req_i = 1'b1;
    @(negedge clk);
    wdg_req_i = 1'b0;
    chk(core_rst_o == 1'b1 && osc_en_o == 1'b1, "R7 restart held", int'({core_rst_o, osc_en_o}), 3);
    meas_start(n);
    chk(n == STAB + 2, "R7 slow restart full window", n, STAB + 2);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    t_por();
    t_wdg();
    t_clear();
    t_lvd();
    t_pin_ext();
    t_restart();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule